// File: doc/BRIEF.md
# Configurable-Width Bus Beat Sequencer

This block sits between a core's memory request port and an external bus whose data path is 64 or 32 bits wide. It accepts one request at a time, made of an address, a byte count, a burst flag and a direction. It checks whether that request fits the bus, then runs an address tenure followed by the right number of data beats. Each beat carries its own byte address, a byte-enable mask and a flag that marks the final beat of the transaction.

The bus width is set by a mode pin. That pin is read only while reset is held, so one die can sit on either bus size. A burst always moves one 32-byte line. It starts at the first beat of the aligned line and steps upward through it. On a narrow bus an 8-byte single transfer becomes a two-beat transfer. The address and data phases are decoupled. A second transaction can finish its address tenure while the first is still moving data, and it then waits in a holding slot until the data path frees up.

Top module: `bseq_top`

## Requirements
- R1: With the wide (64-bit) mode latched, a single request of size 1 to 8 bytes gives exactly one beat. Its address is the request address, its byte enable is `size` ones shifted left by `addr[2:0]` (bit n = byte lane n), and the last flag is set.
- R2: With the wide mode latched, a burst gives four beats at line base + 0, 8, 16 and 24, where line base is the request address with bits [4:0] cleared. Each beat has byte enable 8'hFF, and the last flag is set only on the fourth beat.
- R3: With the narrow (32-bit) mode latched, a single request of size 1 to 4 gives one beat with byte enable `size` ones shifted left by `addr[1:0]`. Byte-enable bits [7:4] are zero on every narrow-mode beat.
- R4: With the narrow mode latched, an 8-byte request whose `addr[2:0]` is zero gives two beats, at addr and addr+4, both with byte enable 8'h0F. The last flag is set on the second beat.
- R5: With the narrow mode latched, a burst gives eight beats at line base + 4k for k = 0..7, each with byte enable 8'h0F. The last flag is set only on the eighth beat.
- R6: Some requests are rejected: size 0, size above 8, or a single that runs past the end of the bus word (`addr[2:0]`+size > 8 on the wide bus, `addr[1:0]`+size > 4 on the narrow bus). On the narrow bus, sizes 5 to 7 and an 8-byte request with `addr[2:0]` nonzero are rejected too. A rejected request is consumed and raises `req_err_o` for one cycle, in the cycle after acceptance. It starts no address tenure and no beats. A legal request leaves `req_err_o` low.
- R7: Each legal request gives exactly one address tenure, in request order. While `abus_valid_o` is high and `abus_ack_i` is low, the address, size, burst and direction outputs hold steady.
- R8: While `dbeat_valid_o` is high and `dbeat_ready_i` is low, the beat does not advance, and its address, byte enable and last flag hold steady.
- R9: A second transaction's address tenure may complete while the first is still in its data phase. At most two transactions are past address acknowledge and not yet through their last beat. While one is held that way, `req_ready_o` stays low, and the held transaction's beats start only after the current one's last beat.
- R10: The bus-width mode is captured while `rst_n` is low. Changes on `wide_mode_i` after reset have no effect on beat count or byte enables.
- R11: While and just after reset, `req_ready_o` is high, and `abus_valid_o`, `dbeat_valid_o` and `req_err_o` are low.
- R12: The request direction (1 = write) appears on `abus_write_o` during the tenure and on `dbeat_write_o` for every beat of that transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode_i | input | 1 | Bus width select, 1 = 64-bit, 0 = 32-bit; captured during reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request slot free; a request is taken when valid and ready are both high |
| req_addr_i | input | ADDR_W | Request byte address |
| req_size_i | input | 4 | Byte count of a single transfer (ignored for bursts) |
| req_burst_i | input | 1 | 1 = 32-byte line burst |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_err_o | output | 1 | One-cycle pulse: last accepted request was rejected |
| abus_valid_o | output | 1 | Address tenure active |
| abus_ack_i | input | 1 | Bus accepts the address |
| abus_addr_o | output | ADDR_W | Tenure address |
| abus_size_o | output | 4 | Tenure byte count |
| abus_burst_o | output | 1 | Tenure is a burst |
| abus_write_o | output | 1 | Tenure direction |
| dbeat_valid_o | output | 1 | Data beat active |
| dbeat_ready_i | input | 1 | Bus completes the beat this cycle |
| dbeat_addr_o | output | ADDR_W | Byte address of the current beat |
| dbeat_be_o | output | 8 | Byte-lane enables of the current beat |
| dbeat_last_o | output | 1 | Current beat is the transaction's final beat |
| dbeat_write_o | output | 1 | Direction of the current beat |

## Verification
The bench builds the block with `ADDR_W` = 20. It resets it twice, once per bus mode, so every beat count, lane mask and rejection rule of both widths is reached in a single run. The small address width keeps line bases and mid-line burst starts readable in the expected-beat model. The bench can randomise or hold the address acknowledge and beat ready inputs, and that brings the stall-hold case and the held second transaction within reach.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int LANES      = 8;
  localparam int LINE_BYTES = 32;
  localparam int LINE_LSB   = $clog2(LINE_BYTES);
  localparam int BEAT_W     = $clog2(LINE_BYTES / 4) + 1;

  typedef struct packed {
    logic              legal;
    logic [BEAT_W-1:0] beats;
    logic [LANES-1:0]  be;
  } xfer_dec_t;

  // contiguous run of 'size' lanes starting at 'lane'
  function automatic logic [LANES-1:0] lane_mask(logic [3:0] size, logic [2:0] lane);
    logic [15:0] m;
    m = (16'd1 << size) - 16'd1;
    m = m << lane;
    return m[LANES-1:0];
  endfunction

  // legality, beat count and first-beat enables of one request
  function automatic xfer_dec_t decode(logic wide, logic burst, logic [3:0] size, logic [2:0] low);
    xfer_dec_t d;
    logic [4:0] end_w;
    logic [4:0] end_n;
    end_w = {2'b00, low} + {1'b0, size};
    end_n = {3'b000, low[1:0]} + {1'b0, size};
    d = '0;
    if (burst) begin
      d.legal = 1'b1;
      d.beats = wide ? BEAT_W'(LINE_BYTES / 8) : BEAT_W'(LINE_BYTES / 4);
      d.be    = wide ? 8'hFF : 8'h0F;
    end else if (wide) begin
      d.legal = (size != 4'd0) && (size <= 4'd8) && (end_w <= 5'd8);
      d.beats = BEAT_W'(1);
      d.be    = lane_mask(size, low);
    end else if (size == 4'd8) begin
      d.legal = (low == 3'd0);
      d.beats = BEAT_W'(2);
      d.be    = 8'h0F;
    end else begin
      d.legal = (size != 4'd0) && (size <= 4'd4) && (end_n <= 5'd4);
      d.beats = BEAT_W'(1);
      d.be    = lane_mask(size, {1'b0, low[1:0]});
    end
    return d;
  endfunction

endpackage

// File: rtl/bseq_addr_stage.sv
module bseq_addr_stage
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic              req_burst_i,
  input  logic              req_write_i,
  output logic              req_err_o,
  output logic              abus_valid_o,
  input  logic              abus_ack_i,
  output logic [ADDR_W-1:0] abus_addr_o,
  output logic [3:0]        abus_size_o,
  output logic              abus_burst_o,
  output logic              abus_write_o,
  input  logic              d_free_i,
  output logic              hand_o,
  output xfer_dec_t         hand_dec_o
);

  typedef enum logic [1:0] {A_IDLE, A_ISSUE, A_HELD} a_state_e;

  a_state_e          st;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        size_q;
  logic              burst_q;
  logic              write_q;
  xfer_dec_t         dec_q;
  logic              err_q;

  // named events for the checks below
  xfer_dec_t req_dec;
  logic      req_fire;
  logic      tenure_done;

  assign req_dec     = decode(wide_i, req_burst_i, req_size_i, req_addr_i[2:0]);
  assign req_ready_o = (st == A_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign tenure_done = (st == A_ISSUE) && abus_ack_i;
  assign hand_o      = (tenure_done || (st == A_HELD)) && d_free_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= A_IDLE;
      err_q   <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= 1'b0;
      write_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      err_q <= req_fire && !req_dec.legal;
      case (st)
        A_IDLE: if (req_fire && req_dec.legal) begin
          st      <= A_ISSUE;
          addr_q  <= req_addr_i;
          size_q  <= req_size_i;
          burst_q <= req_burst_i;
          write_q <= req_write_i;
          dec_q   <= req_dec;
        end
        A_ISSUE: if (abus_ack_i) st <= d_free_i ? A_IDLE : A_HELD;
        A_HELD:  if (d_free_i) st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  assign req_err_o    = err_q;
  assign abus_valid_o = (st == A_ISSUE);
  assign abus_addr_o  = addr_q;
  assign abus_size_o  = size_q;
  assign abus_burst_o = burst_q;
  assign abus_write_o = write_q;
  assign hand_dec_o   = dec_q;

  // R7
  abus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_valid_o && !abus_ack_i) |=>
      (abus_valid_o && $stable(abus_addr_o) && $stable(abus_size_o)
       && $stable(abus_burst_o) && $stable(abus_write_o)));

  // R6
  err_no_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err_o |-> (!abus_valid_o && $past(req_fire)));

  // R9
  held_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_done && !d_free_i) |=> !req_ready_o);

endmodule

// File: rtl/bseq_data_stage.sv
module bseq_data_stage
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              load_burst_i,
  input  logic              load_write_i,
  input  xfer_dec_t         load_dec_i,
  output logic              d_free_o,
  output logic              dbeat_valid_o,
  input  logic              dbeat_ready_i,
  output logic [ADDR_W-1:0] dbeat_addr_o,
  output logic [LANES-1:0]  dbeat_be_o,
  output logic              dbeat_last_o,
  output logic              dbeat_write_o
);

  // address of beat 'idx' from the transaction base
  function automatic logic [ADDR_W-1:0] beat_addr(logic [ADDR_W-1:0] base,
                                                  logic [BEAT_W-1:0] idx, logic wide);
    return base + (ADDR_W'(idx) << (wide ? 3 : 2));
  endfunction

  logic              busy;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] idx_q;
  logic [BEAT_W-1:0] nbeats_q;
  logic [LANES-1:0]  be_q;
  logic              write_q;

  logic [ADDR_W-1:0] load_base;
  logic              beat_fire;
  logic              xfer_end;

  assign load_base = load_burst_i ? {load_addr_i[ADDR_W-1:LINE_LSB], LINE_LSB'(0)} : load_addr_i;
  assign beat_fire = busy && dbeat_ready_i;
  assign xfer_end  = beat_fire && dbeat_last_o;
  assign d_free_o  = !busy || xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      nbeats_q <= '0;
      be_q     <= '0;
      write_q  <= 1'b0;
    end else if (load_i) begin
      busy     <= 1'b1;
      base_q   <= load_base;
      idx_q    <= '0;
      nbeats_q <= load_dec_i.beats;
      be_q     <= load_dec_i.be;
      write_q  <= load_write_i;
    end else if (beat_fire) begin
      if (dbeat_last_o) busy <= 1'b0;
      else              idx_q <= idx_q + 1'b1;
    end
  end

  assign dbeat_valid_o = busy;
  assign dbeat_addr_o  = beat_addr(base_q, idx_q, wide_i);
  assign dbeat_be_o    = be_q;
  assign dbeat_last_o  = busy && (idx_q == nbeats_q - 1'b1);
  assign dbeat_write_o = write_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbeat_valid_o && !dbeat_ready_i) |=>
      (dbeat_valid_o && $stable(dbeat_addr_o) && $stable(dbeat_be_o) && $stable(dbeat_last_o)));

  // R2
  beat_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !dbeat_last_o) |=> dbeat_valid_o);

  // R1
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbeat_valid_o |-> (dbeat_be_o != '0));

  // R3
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && dbeat_valid_o) |-> (dbeat_be_o[7:4] == 4'h0));

  // R9
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!busy || xfer_end));

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic              req_burst_i,
  input  logic              req_write_i,
  output logic              req_err_o,
  output logic              abus_valid_o,
  input  logic              abus_ack_i,
  output logic [ADDR_W-1:0] abus_addr_o,
  output logic [3:0]        abus_size_o,
  output logic              abus_burst_o,
  output logic              abus_write_o,
  output logic              dbeat_valid_o,
  input  logic              dbeat_ready_i,
  output logic [ADDR_W-1:0] dbeat_addr_o,
  output logic [7:0]        dbeat_be_o,
  output logic              dbeat_last_o,
  output logic              dbeat_write_o
);

  logic      wide_q;
  logic      d_free;
  logic      hand;
  xfer_dec_t hand_dec;

  // width mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= wide_mode_i;
  end

  bseq_addr_stage #(.ADDR_W(ADDR_W)) addr_stage_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_i       (wide_q),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_size_i   (req_size_i),
    .req_burst_i  (req_burst_i),
    .req_write_i  (req_write_i),
    .req_err_o    (req_err_o),
    .abus_valid_o (abus_valid_o),
    .abus_ack_i   (abus_ack_i),
    .abus_addr_o  (abus_addr_o),
    .abus_size_o  (abus_size_o),
    .abus_burst_o (abus_burst_o),
    .abus_write_o (abus_write_o),
    .d_free_i     (d_free),
    .hand_o       (hand),
    .hand_dec_o   (hand_dec)
  );

  bseq_data_stage #(.ADDR_W(ADDR_W)) data_stage_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wide_i        (wide_q),
    .load_i        (hand),
    .load_addr_i   (abus_addr_o),
    .load_burst_i  (abus_burst_o),
    .load_write_i  (abus_write_o),
    .load_dec_i    (hand_dec),
    .d_free_o      (d_free),
    .dbeat_valid_o (dbeat_valid_o),
    .dbeat_ready_i (dbeat_ready_i),
    .dbeat_addr_o  (dbeat_addr_o),
    .dbeat_be_o    (dbeat_be_o),
    .dbeat_last_o  (dbeat_last_o),
    .dbeat_write_o (dbeat_write_o)
  );

  // transactions past address acknowledge and not yet through their last beat
  logic       tenure_done;
  logic       xfer_done;
  logic [1:0] in_flight;

  assign tenure_done = abus_valid_o && abus_ack_i;
  assign xfer_done   = dbeat_valid_o && dbeat_ready_i && dbeat_last_o;

  always_ff @(posedge clk) begin
    if (!rst_n) in_flight <= '0;
    else        in_flight <= in_flight + {1'b0, tenure_done} - {1'b0, xfer_done};
  end

  // R9
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= 2'd2);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(wide_q));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $fell(rst_n) |=> (!abus_valid_o && !dbeat_valid_o && req_ready_o));

endmodule

// File: tb/bseq_top_tb.sv
`timescale 1ns/1ps
module bseq_top_tb_top;

  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    logic [3:0]    size;
    logic          burst;
    logic          wr;
    string         tag;
  } ten_t;

  typedef struct {
    logic [AW-1:0] addr;
    logic [7:0]    be;
    logic          last;
    logic          wr;
    string         tag;
  } beat_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_mode_i = 1'b1;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [3:0]    req_size_i = '0;
  logic          req_burst_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic          req_err_o;
  logic          abus_valid_o;
  logic          abus_ack_i = 1'b0;
  logic [AW-1:0] abus_addr_o;
  logic [3:0]    abus_size_o;
  logic          abus_burst_o;
  logic          abus_write_o;
  logic          dbeat_valid_o;
  logic          dbeat_ready_i = 1'b0;
  logic [AW-1:0] dbeat_addr_o;
  logic [7:0]    dbeat_be_o;
  logic          dbeat_last_o;
  logic          dbeat_write_o;

  bseq_top #(.ADDR_W(AW)) dut_i (.*);

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int beats_seen = 0;
  int tens_seen = 0;
  bit cur_wide = 1'b1;
  int ack_mode = 2;   // 0 hold low, 1 always, 2 pseudo-random
  int rdy_mode = 2;
  logic [15:0] lfsr = 16'hACE1;

  ten_t  ten_q[$];
  beat_t beat_q[$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // input drivers, one step after the rising edge
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    abus_ack_i    <= abus_valid_o && (ack_mode == 1 || (ack_mode == 2 && lfsr[3]));
    dbeat_ready_i <= (rdy_mode == 1) || (rdy_mode == 2 && lfsr[7]);
  end

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && abus_valid_o && abus_ack_i) begin
      tens_seen++;
      if (ten_q.size() == 0) begin
        check(1'b0, "R7", "unexpected tenure", abus_addr_o, 0);
      end else begin
        ten_t t;
        t = ten_q.pop_front();
        check(abus_addr_o == t.addr && abus_burst_o == t.burst && abus_size_o == t.size,
              t.tag, "tenure addr", abus_addr_o, t.addr);
        // R12
        check(abus_write_o == t.wr, "R12", "tenure dir", abus_write_o, t.wr);
      end
    end
    if (rst_n && dbeat_valid_o && dbeat_ready_i) begin
      beats_seen++;
      if (beat_q.size() == 0) begin
        check(1'b0, "R9", "unexpected beat", dbeat_addr_o, 0);
      end else begin
        beat_t b;
        b = beat_q.pop_front();
        check(dbeat_addr_o == b.addr, b.tag, "beat addr", dbeat_addr_o, b.addr);
        check(dbeat_be_o == b.be, b.tag, "beat be", dbeat_be_o, b.be);
        check(dbeat_last_o == b.last, b.tag, "beat last", dbeat_last_o, b.last);
        // R12
        check(dbeat_write_o == b.wr, "R12", "beat dir", dbeat_write_o, b.wr);
      end
    end
  end

  // expected beats, restated from the requirements
  task automatic expect_beats(logic [AW-1:0] a, logic [3:0] sz, bit burst, bit wr, string tag);
    int bw;
    int n;
    logic [AW-1:0] base;
    logic [7:0] be;
    bw = cur_wide ? 8 : 4;
    if (burst) begin
      n = 32 / bw;
      base = a & ~AW'(31);
      be = cur_wide ? 8'hFF : 8'h0F;
    end else if (!cur_wide && sz == 8) begin
      n = 2;
      base = a;
      be = 8'h0F;
    end else begin
      n = 1;
      base = a;
      be = 8'(((1 << sz) - 1) << (a % bw));
    end
    ten_q.push_back('{a, sz, burst, wr, tag});
    for (int k = 0; k < n; k++)
      beat_q.push_back('{base + AW'(k * bw), be, (k == n - 1), wr, tag});
  endtask

  task automatic send(logic [AW-1:0] a, logic [3:0] sz, bit burst, bit wr, bit bad_req, string tag);
    if (!bad_req) expect_beats(a, sz, burst, wr, tag);
    @(posedge clk); #1;
    req_addr_i = a; req_size_i = sz; req_burst_i = burst; req_write_i = wr;
    req_valid_i = 1'b1;
    do @(negedge clk); while (!req_ready_o);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    @(negedge clk);
    // R6
    check(req_err_o == bad_req, "R6", "error flag", req_err_o, bad_req);
    if (bad_req) check(!abus_valid_o, "R6", "no tenure on reject", abus_valid_o, 0);
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((ten_q.size() != 0 || beat_q.size() != 0 || dbeat_valid_o) && n < 3000) begin
      @(negedge clk); n++;
    end
    check(ten_q.size() == 0 && beat_q.size() == 0, tag, "drain", beat_q.size(), 0);
  endtask

  task automatic do_reset(bit wide);
    @(posedge clk); #1;
    rst_n = 1'b0; wide_mode_i = wide; cur_wide = wide;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    check(req_ready_o && !abus_valid_o && !dbeat_valid_o && !req_err_o, "R11",
          "state in reset", {req_ready_o, abus_valid_o, dbeat_valid_o, req_err_o}, 4'b1000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o && !abus_valid_o && !dbeat_valid_o, "R11", "state after reset",
          {req_ready_o, abus_valid_o, dbeat_valid_o}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    ack_mode = 2; rdy_mode = 2;

    // R1 wide singles
    send(20'h00100, 4'd1, 1'b0, 1'b0, 1'b0, "R1");
    send(20'h00103, 4'd4, 1'b0, 1'b1, 1'b0, "R1");
    send(20'h00100, 4'd8, 1'b0, 1'b0, 1'b0, "R1");
    send(20'h00106, 4'd2, 1'b0, 1'b1, 1'b0, "R1");
    // R2 wide bursts, one from mid-line
    send(20'h00240, 4'd0, 1'b1, 1'b0, 1'b0, "R2");
    send(20'h00258, 4'd8, 1'b1, 1'b1, 1'b0, "R2");
    // R6 wide rejects
    send(20'h00100, 4'd0, 1'b0, 1'b0, 1'b1, "R6");
    send(20'h00105, 4'd4, 1'b0, 1'b0, 1'b1, "R6");
    send(20'h00100, 4'd9, 1'b0, 1'b0, 1'b1, "R6");
    drain("R2");

    // R8 stall hold
    rdy_mode = 0; ack_mode = 1;
    send(20'h00380, 4'd0, 1'b1, 1'b0, 1'b0, "R8");
    begin
      logic [AW-1:0] a0;
      logic [7:0] b0;
      int seen0;
      while (!dbeat_valid_o) @(negedge clk);
      a0 = dbeat_addr_o; b0 = dbeat_be_o; seen0 = beats_seen;
      repeat (5) @(negedge clk);
      check(dbeat_valid_o && dbeat_addr_o == a0 && dbeat_be_o == b0, "R8",
            "stalled beat held", dbeat_addr_o, a0);
      check(beats_seen == seen0, "R8", "no advance", beats_seen, seen0);
    end
    rdy_mode = 2;
    drain("R8");

    // R9 second tenure completes during first data phase
    rdy_mode = 0; ack_mode = 1;
    begin
      int t0;
      int b0;
      int n = 0;
      t0 = tens_seen; b0 = beats_seen;
      send(20'h00400, 4'd0, 1'b1, 1'b0, 1'b0, "R9");
      send(20'h00510, 4'd4, 1'b0, 1'b1, 1'b0, "R9");
      while (tens_seen < t0 + 2 && n < 50) begin @(negedge clk); n++; end
      check(tens_seen == t0 + 2, "R9", "second tenure done", tens_seen, t0 + 2);
      check(beats_seen == b0 && dbeat_valid_o, "R9", "first data still pending", beats_seen, b0);
      repeat (3) @(negedge clk);
      check(!req_ready_o, "R9", "request blocked while held", req_ready_o, 0);
    end
    rdy_mode = 1;
    drain("R9");
    rdy_mode = 2; ack_mode = 2;

    // R10 mode pin change after reset is ignored
    wide_mode_i = 1'b0;
    send(20'h00080, 4'd0, 1'b1, 1'b0, 1'b0, "R10");
    send(20'h00083, 4'd5, 1'b0, 1'b0, 1'b0, "R10");
    drain("R10");

    do_reset(1'b0);
    // R3 narrow singles
    send(20'h00011, 4'd1, 1'b0, 1'b0, 1'b0, "R3");
    send(20'h00012, 4'd2, 1'b0, 1'b1, 1'b0, "R3");
    send(20'h00010, 4'd4, 1'b0, 1'b0, 1'b0, "R3");
    // R4 narrow 8-byte
    send(20'h00018, 4'd8, 1'b0, 1'b1, 1'b0, "R4");
    // R5 narrow burst from mid-line
    send(20'h0003C, 4'd0, 1'b1, 1'b0, 1'b0, "R5");
    // R6 narrow rejects
    send(20'h00010, 4'd5, 1'b0, 1'b0, 1'b1, "R6");
    send(20'h00014, 4'd8, 1'b0, 1'b0, 1'b1, "R6");
    send(20'h00013, 4'd2, 1'b0, 1'b0, 1'b1, "R6");
    drain("R5");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule